// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands, each `WIDTH` bits wide, and returns the full signed product of `2*WIDTH` bits. It works one step at a time using radix-2 Booth recoding. Each step compares the low bit of the multiplier register with the bit that was shifted out on the previous step. From that pair it adds the multiplicand, subtracts it, or leaves the accumulator unchanged. It then shifts accumulator, multiplier register and saved bit right by one, keeping the sign. Because of this, negative operands need no correction at the end.

A client raises `start` for one cycle while the block is idle and presents both operands. The block captures them, raises `busy`, and runs one step per clock for `WIDTH` clocks. It then pulses `done` for one cycle and holds the product until the next accepted start.

The `product` output always shows the concatenation of accumulator and multiplier register. Between steps it therefore exposes the partial state of the recoding.

Top module: `booth_mult`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` sampled high while `busy` is 0 is accepted. On the next cycle `busy` is 1 and `product` equals {WIDTH zero bits, multiplier}.
- R3: `done` rises exactly `WIDTH` clock edges after the accepting edge, lasts one cycle, and `busy` falls on the same edge.
- R4: When `done` is 1, `product` equals the signed product of the captured multiplicand and multiplier, sign-extended to `2*WIDTH` bits.
- R5: Operand values at the most negative end give exact results. With WIDTH=4: -8 times -8 gives 64, -8 times 7 gives -56, 7 times -8 gives -56.
- R6: `start` raised while `busy` is 1 is ignored. The running operation completes on schedule with its original result.
- R7: Changes on `multiplicand` or `multiplier` while `busy` is 1 have no effect on the result.
- R8: After `done`, `product` stays unchanged and `done` stays 0 until the next accepted start.
- R9: After each step, `product` shows {low WIDTH bits of accumulator, multiplier register}. For multiplicand 0111 and multiplier 0011 at WIDTH=4, the value is 11001001 after the first step and 11100100 after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a multiplication (honoured only when idle) |
| multiplicand | input | WIDTH | Signed multiplicand, captured at accepted start |
| multiplier | input | WIDTH | Signed multiplier, captured at accepted start |
| busy | output | 1 | High while steps are running |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 2*WIDTH | Accumulator and multiplier register; final signed product after done |

## Verification
- **Timing after the accepting edge:**
  - `busy` and the loaded value on `product` are due one edge later.
  - Each partial value is due one edge after the previous one.
  - `done` and the final product are due exactly `WIDTH` edges later.
- **How the bench keeps to that timing:** It counts edges from the accepting edge and samples one time unit after each rising edge. It checks that `done` stays low on every earlier edge and that it is gone on the following edge.
- **Hold checks:** Hold behaviour is checked on later edges after the operand inputs have been changed.
- **Stimulus:** Random operand pairs from a fixed seed are mixed with the extreme-value corners. Some runs also disturb the inputs while the block is busy.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;

    // Recoding of the bit pair {current LSB, previously shifted-out bit}
    function automatic booth_op_e booth_decode(input logic lsb, input logic prev);
        case ({lsb, prev})
            2'b10:   return OP_SUB;
            2'b01:   return OP_ADD;
            default: return OP_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    state_e        state;
    logic [CW-1:0] cnt;

    assign busy = (state == ST_RUN);
    assign step = busy;
    assign load = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                    end
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Step count never exceeds the operand width (R3)
    assert_cnt_window_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> cnt <= LAST);

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && cnt == '0));

    // A start during a run neither restarts nor stalls the count (R6)
    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && start && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
    import booth_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mcand_in,
    input  logic [WIDTH-1:0]   mplier_in,
    output logic [2*WIDTH-1:0] prod
);
    // One guard bit so that negating the most negative multiplicand is exact
    localparam int AW = WIDTH + 1;

    logic [AW-1:0]    acc;
    logic [WIDTH-1:0] qreg;
    logic             qprev;
    logic [WIDTH-1:0] mcand;

    logic [AW-1:0]    mext;
    logic [AW-1:0]    sum;
    booth_op_e        op;

    assign mext = {mcand[WIDTH-1], mcand};
    assign op   = booth_decode(qreg[0], qprev);

    always_comb begin
        case (op)
            OP_ADD:  sum = acc + mext;
            OP_SUB:  sum = acc + (~mext + 1'b1);
            default: sum = acc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            qreg  <= '0;
            qprev <= 1'b0;
            mcand <= '0;
        end else if (load) begin
            acc   <= '0;
            qreg  <= mplier_in;
            qprev <= 1'b0;
            mcand <= mcand_in;
        end else if (step) begin
            acc   <= {sum[AW-1], sum[AW-1:1]};
            qreg  <= {sum[0], qreg[WIDTH-1:1]};
            qprev <= qreg[0];
        end
    end

    assign prod = {acc[WIDTH-1:0], qreg};

    // Outside load and step the product register is frozen (R8)
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(prod));

    // Captured multiplicand cannot follow the input during a run (R7)
    assert_mcand_kept_R7: assert property (@(posedge clk) disable iff (rst)
        step |=> $stable(mcand));

    // Each step moves the old multiplier LSB into the saved bit (R9)
    assert_shift_chain_R9: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (qprev == $past(qreg[0])));

endmodule

// File: rtl/booth_mult.sv
module booth_mult
    import booth_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WIDTH-1:0]   multiplicand,
    input  logic [WIDTH-1:0]   multiplier,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    logic load;
    logic step;

    booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    booth_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .mcand_in  (multiplicand),
        .mplier_in (multiplier),
        .prod      (product)
    );

    // An accepted start loads the multiplier into the low half (R2)
    assert_load_view_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> product == {{WIDTH{1'b0}}, $past(multiplier)});

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && product == '0));

endmodule

// File: tb/test_booth_mult.sv
`timescale 1ns/1ps
module test_booth_mult;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [N-1:0]   mcand_i = '0;
    logic [N-1:0]   mplier_i = '0;
    logic           busy;
    logic           done;
    logic [2*N-1:0] product;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    booth_mult #(.WIDTH(N)) i_booth_mult (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .multiplicand (mcand_i),
        .multiplier   (mplier_i),
        .busy         (busy),
        .done         (done),
        .product      (product)
    );

    function automatic logic [2*N-1:0] ref_prod(input logic [N-1:0] a, input logic [N-1:0] b);
        logic signed [2*N-1:0] sa, sb, p;
        sa = $signed({{N{a[N-1]}}, a});
        sb = $signed({{N{b[N-1]}}, b});
        p  = sa * sb;
        return p;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // disturb: pulse start and change operands while busy (R6, R7)
    task automatic run_mult(input logic [N-1:0] a, input logic [N-1:0] b,
                            input bit trace, input bit disturb, input string tag);
        logic [2*N-1:0] exp_p;
        exp_p = ref_prod(a, b);
        @(posedge clk); #1;
        mcand_i = a; mplier_i = b; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        check("R2 busy", busy, 1);
        check("R2 load view", product, {{N{1'b0}}, b});
        if (disturb) begin
            mcand_i = ~a; mplier_i = b + 1'b1; start = 1'b1;
        end
        for (int k = 1; k <= N; k++) begin
            @(posedge clk); #1;
            if (trace && k == 1) check("R9 step1", product, 8'hC9);
            if (trace && k == 2) check("R9 step2", product, 8'hE4);
            if (k < N) begin
                check("R3 no early done", done, 0);
                check(disturb ? "R6 busy kept" : "R3 busy kept", busy, 1);
            end else begin
                check("R3 done due", done, 1);
                check("R3 busy falls", busy, 0);
                check(disturb ? "R7 result" : tag, product, exp_p);
            end
        end
        start = 1'b0;
        mcand_i = mcand_i + 1'b1; mplier_i = mplier_i - 1'b1;
        @(posedge clk); #1;
        check("R3 done one cycle", done, 0);
        check("R8 hold", product, exp_p);
        @(posedge clk); #1;
        check("R8 hold later", product, exp_p);
        check("R8 no done", done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
    end

    initial begin
        int unused;
        unused = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 product", product, 0);

        run_mult(4'd7, 4'd3, 1'b1, 1'b0, "R4 7x3");
        run_mult(4'h8, 4'h8, 1'b0, 1'b0, "R5 -8x-8");
        run_mult(4'h8, 4'd7, 1'b0, 1'b0, "R5 -8x7");
        run_mult(4'd7, 4'h8, 1'b0, 1'b0, "R5 7x-8");
        run_mult(4'hF, 4'hF, 1'b0, 1'b0, "R4 -1x-1");
        run_mult(4'd0, 4'h9, 1'b0, 1'b0, "R4 zero");
        run_mult(4'h8, 4'h8, 1'b0, 1'b1, "R6 -8x-8 disturbed");
        run_mult(4'd5, 4'hB, 1'b0, 1'b1, "R6 5x-5 disturbed");
        for (int i = 0; i < 150; i++) begin
            logic [N-1:0] ra, rb;
            ra = N'($urandom);
            rb = N'($urandom);
            run_mult(ra, rb, 1'b0, ($urandom % 4) == 0, "R4 random");
        end
        summary();
    end
endmodule